// File: doc/BRIEF.md
# Command Pointer Mailbox Registers

This block is the host-visible register window of a disk controller that takes its commands as pointers to parameter blocks held in memory. Software writes a 32-bit block pointer one byte at a time, plus an address-modifier byte, and then writes the post bit of the control/status byte. The block latches the pointer and offers it to the controller core on a valid/ready port.

Finished blocks travel the other way. The core offers a completion pointer on a second valid/ready port, and the block keeps it in a single-entry holding slot. When the window is free, the block copies the pointer into the same four address bytes and raises a remove flag. Software reads the pointer and writes the flag back to release it. The control/status byte also carries a soft-reset strobe with a busy indication, a fatal-error summary, a maintenance-mode bit and a software semaphore. A separate byte holds the last fatal code that the core reported.

Top module: `cmd_mailbox_regs`

## Requirements
- R1: Registers sit only at odd byte offsets: 1, 3, 5 and 7 hold pointer bytes 0 (LSB) to 3 (MSB), 9 holds the modifier, 11 the control/status byte and 13 the fatal code. Even offsets read 0x00, and writing to them changes nothing.
- R2: Writing 1 to status bit 2 while no post is pending latches the pointer and modifier and raises cmd_valid. Bit 2 reads 1 until the cycle after a cmd_valid/cmd_ready handshake. A second post while one is pending is ignored.
- R3: While a post is pending, cmd_addr and cmd_mod hold steady, and host writes to the pointer bytes are ignored.
- R4: When the modifier is 0x3D, cmd_addr[31:24] is zero. Any other modifier, such as 0x0D, passes all 32 pointer bits.
- R5: A completion pointer accepted on done_valid/done_ready appears in the four pointer bytes with status bit 1 set two clock edges after the handshake. Writing 1 to bit 1 clears the flag.
- R6: Only one completion is shown at a time. A further completion waits in the slot with done_ready low, and it is shown only after bit 1 is cleared.
- R7: A completion is not moved into the pointer bytes while a post is pending, nor in the cycle in which the host posts. In that cycle the post uses the old pointer value.
- R8: When a completion transfer and a host pointer-byte write fall in the same cycle, the completion wins.
- R9: Writing to status bit 7 has no effect. Writing 1 to bit 3 starts a soft reset. Bits 7 and 3 then read 1 for exactly RST_CYCLES clock edges and then read 0.
- R10: Soft reset clears the pending post, the remove flag, the holding slot, the fatal code, maintenance mode and the semaphore, and it keeps the pointer bytes. During soft reset, cmd_valid and done_ready are low and control/status writes are ignored.
- R11: A fatal_valid pulse loads fatal_code into offset 13, and status bit 6 reads 1 while that code is non-zero. Host writes to offset 13 are ignored. Only soft reset clears the code.
- R12: Status bits 5 (maintenance, also on maint_mode) and 0 (semaphore) read back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 4 | Register byte offset |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for host_addr |
| cmd_valid | output | 1 | Posted pointer offered to core |
| cmd_ready | input | 1 | Core takes posted pointer |
| cmd_addr | output | 32 | Posted pointer (upper byte cleared in 24-bit mode) |
| cmd_mod | output | 8 | Posted modifier |
| done_valid | input | 1 | Core offers completion pointer |
| done_ready | output | 1 | Holding slot free |
| done_addr | input | 32 | Completion pointer |
| fatal_valid | input | 1 | Core reports fatal code |
| fatal_code | input | 8 | Fatal code value |
| maint_mode | output | 1 | Maintenance mode bit |
| soft_rst | output | 1 | Soft reset in progress |

## Verification
Two actions can share one clock edge. The first is moving a held completion into the pointer bytes. The second is either a host pointer-byte write or a host post. Each collision is provoked by driving the host write in the cycle right after the completion handshake, which is the cycle in which the transfer is due. In the write case, the bytes must show the completion (R8). In the post case, the core must receive the old pointer and the completion must stay hidden until the post is accepted (R7). Randomised post/complete rounds with mixed modifiers surround these directed collisions.

// File: rtl/cmd_mailbox_regs.sv
module cmd_mailbox_regs #(
  parameter int unsigned RST_CYCLES = 1000,
  parameter logic [7:0]  MOD_A24    = 8'h3D
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  host_addr,
  input  logic        host_wr,
  input  logic [7:0]  host_wdata,
  output logic [7:0]  host_rdata,
  output logic        cmd_valid,
  input  logic        cmd_ready,
  output logic [31:0] cmd_addr,
  output logic [7:0]  cmd_mod,
  input  logic        done_valid,
  output logic        done_ready,
  input  logic [31:0] done_addr,
  input  logic        fatal_valid,
  input  logic [7:0]  fatal_code,
  output logic        maint_mode,
  output logic        soft_rst
);
  localparam int CW = $clog2(RST_CYCLES + 1);
  localparam logic [3:0] OFS_MOD = 4'd9, OFS_CSR = 4'd11, OFS_FAT = 4'd13;

  logic [31:0]   ptr_q, cpl_q;
  logic [7:0]    mod_q, fat_q;
  logic [CW-1:0] rst_cnt;
  logic          add_pend, rio, cpl_full, sem;

  wire rst_act = (rst_cnt != '0);
  wire wr_csr  = host_wr && host_addr == OFS_CSR && !rst_act;
  wire rst_go  = wr_csr && host_wdata[3];
  wire post    = wr_csr && host_wdata[2] && !add_pend;
  wire ptr_wr  = host_wr && !host_addr[3] && host_addr[0] && !add_pend;
  wire xfer    = cpl_full && !rio && !add_pend && !post;

  assign cmd_valid  = add_pend;
  assign done_ready = !cpl_full && !rst_act;
  assign soft_rst   = rst_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0; cpl_q <= '0; mod_q <= '0; fat_q <= '0; rst_cnt <= '0;
      add_pend <= 1'b0; rio <= 1'b0; cpl_full <= 1'b0; sem <= 1'b0;
      maint_mode <= 1'b0; cmd_addr <= '0; cmd_mod <= '0;
    end else begin
      if (rst_act) rst_cnt <= rst_cnt - 1'b1;
      if (xfer) ptr_q <= cpl_q;
      else if (ptr_wr) ptr_q[8*host_addr[2:1] +: 8] <= host_wdata;
      if (host_wr && host_addr == OFS_MOD && !add_pend) mod_q <= host_wdata;
      if (rst_go) begin
        rst_cnt <= CW'(RST_CYCLES);
        add_pend <= 1'b0; rio <= 1'b0; cpl_full <= 1'b0;
        fat_q <= '0; maint_mode <= 1'b0; sem <= 1'b0;
      end else begin
        if (wr_csr) begin
          maint_mode <= host_wdata[5];
          sem        <= host_wdata[0];
        end
        if (post) begin
          add_pend <= 1'b1;
          cmd_addr <= (mod_q == MOD_A24) ? {8'h00, ptr_q[23:0]} : ptr_q;
          cmd_mod  <= mod_q;
        end else if (add_pend && cmd_ready) add_pend <= 1'b0;
        if (xfer) rio <= 1'b1;
        else if (wr_csr && host_wdata[1]) rio <= 1'b0;
        if (done_valid && done_ready) begin
          cpl_q <= done_addr; cpl_full <= 1'b1;
        end else if (xfer) cpl_full <= 1'b0;
        if (fatal_valid && !rst_act) fat_q <= fatal_code;
      end
    end
  end

  always_comb begin
    host_rdata = 8'h00;
    if (host_addr[0]) begin
      if (!host_addr[3]) host_rdata = ptr_q[8*host_addr[2:1] +: 8];
      else if (host_addr == OFS_MOD) host_rdata = mod_q;
      else if (host_addr == OFS_CSR)
        host_rdata = {rst_act, fat_q != 8'h00, maint_mode, 1'b0, rst_act, add_pend, rio, sem};
      else if (host_addr == OFS_FAT) host_rdata = fat_q;
    end
  end

  // R3
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    add_pend && !cmd_ready && !rst_go |=> add_pend && $stable(cmd_addr) && $stable(cmd_mod));
  // R4
  narrow_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_mod == MOD_A24 |-> cmd_addr[31:24] == 8'h00);
  // R6
  one_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid && done_ready |=> !done_ready);
  // R7
  no_show_while_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rio) |-> !$past(add_pend));
  // R10
  quiet_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> !cmd_valid && !done_ready);
  // R11
  fatal_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_go && !fatal_valid |=> fat_q == $past(fat_q));
endmodule

// File: tb/cmd_mailbox_regs_tb.sv
module cmd_mailbox_regs_tb_top;
  localparam int RST = 16;
  logic clk = 0, rst_n = 0;
  logic [3:0] host_addr = 0;
  logic host_wr = 0, cmd_ready = 0, done_valid = 0, fatal_valid = 0;
  logic [7:0] host_wdata = 0, fatal_code = 0, host_rdata, cmd_mod;
  logic [31:0] done_addr = 0, cmd_addr;
  logic cmd_valid, done_ready, maint_mode, soft_rst;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  cmd_mailbox_regs #(.RST_CYCLES(RST)) dut_i (.*);

  function automatic logic [31:0] exp_cmd(input logic [31:0] a, input logic [7:0] m);
    return (m == 8'h3D) ? {8'h00, a[23:0]} : a;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); host_addr = a; host_wdata = d; host_wr = 1;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    host_addr = a; #1 d = host_rdata;
  endtask

  task automatic rd_ptr(output logic [31:0] p);
    logic [7:0] b;
    for (int i = 0; i < 4; i++) begin rd(4'(2*i+1), b); p[8*i +: 8] = b; end
  endtask

  task automatic load(input logic [31:0] p, input logic [7:0] m);
    for (int i = 0; i < 4; i++) wr(4'(2*i+1), p[8*i +: 8]);
    wr(4'd9, m);
  endtask

  task automatic accept();
    @(negedge clk); cmd_ready = 1; @(negedge clk); cmd_ready = 0;
  endtask

  task automatic complete(input logic [31:0] p);
    @(negedge clk); done_valid = 1; done_addr = p; @(negedge clk); done_valid = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    logic [31:0] p, a, q;
    logic [7:0] m;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk); rst_n = 1;
    @(negedge clk);
    rd(4'd11, b); chk("R9 reset csr", b, 8'h00);
    rd_ptr(p);   chk("R1 reset ptr", p, 0);
    chk("R10 reset done_ready", done_ready, 1);
    chk("R2 reset cmd_valid", cmd_valid, 0);

    // R1 even offsets
    wr(4'd0, 8'hFF); wr(4'd10, 8'h08);
    rd(4'd0, b);  chk("R1 even read", b, 8'h00);
    rd(4'd1, b);  chk("R1 even write no effect", b, 8'h00);
    rd(4'd11, b); chk("R1 even no reset", b, 8'h00);

    // R9 bit7 write ignored, R12 maint/sem
    wr(4'd11, 8'h80); rd(4'd11, b); chk("R9 bit7 write ignored", b, 8'h00);
    wr(4'd11, 8'h21); rd(4'd11, b); chk("R12 maint sem readback", b, 8'h21);
    chk("R12 maint_mode pin", maint_mode, 1);
    wr(4'd11, 8'h00); rd(4'd11, b); chk("R12 cleared", b, 8'h00);

    // R11 fatal
    @(negedge clk); fatal_valid = 1; fatal_code = 8'h70; @(negedge clk); fatal_valid = 0;
    rd(4'd13, b); chk("R11 fatal code", b, 8'h70);
    rd(4'd11, b); chk("R11 fatal bit", b, 8'h40);
    wr(4'd13, 8'h00); wr(4'd11, 8'h02);
    rd(4'd13, b); chk("R11 fatal sticky", b, 8'h70);

    // R2 R3 R4 post, 24-bit
    load(32'hA1B2C3D4, 8'h3D); wr(4'd11, 8'h04);
    chk("R2 cmd_valid", cmd_valid, 1);
    chk("R4 narrow addr", cmd_addr, 32'h00B2C3D4);
    rd(4'd11, b); chk("R2 pending bit", b, 8'h44);
    wr(4'd1, 8'h99); rd(4'd1, b); chk("R3 ptr write ignored", b, 8'hD4);
    wr(4'd9, 8'h0D); wr(4'd11, 8'h04);
    chk("R3 cmd_addr held", cmd_addr, 32'h00B2C3D4);
    chk("R3 cmd_mod held", cmd_mod, 8'h3D);
    accept();
    chk("R2 accepted", cmd_valid, 0);
    rd(4'd11, b); chk("R2 pending clear", b, 8'h40);

    // R4 32-bit
    load(32'hA1B2C3D4, 8'h0D); wr(4'd11, 8'h04);
    chk("R4 wide addr", cmd_addr, 32'hA1B2C3D4);
    accept();

    // R5 R6 completion and one at a time
    complete(32'h11223344);
    @(negedge clk);
    rd(4'd11, b); chk("R5 remove bit", b, 8'h42);
    rd_ptr(p); chk("R5 completion ptr", p, 32'h11223344);
    complete(32'h55667788);
    chk("R6 slot full", done_ready, 0);
    repeat (3) @(negedge clk);
    rd_ptr(p); chk("R6 first still shown", p, 32'h11223344);
    wr(4'd11, 8'h02);
    rd(4'd11, b); chk("R5 remove cleared", b, 8'h40);
    @(negedge clk);
    rd_ptr(p); chk("R6 second shown", p, 32'h55667788);
    rd(4'd11, b); chk("R6 second flag", b, 8'h42);
    wr(4'd11, 8'h02);

    // R7 held while add pending
    load(32'h0BADF00D, 8'h0D); wr(4'd11, 8'h04);
    complete(32'hCAFE0001);
    repeat (3) @(negedge clk);
    rd(4'd11, b); chk("R7 no remove while pending", b, 8'h44);
    rd_ptr(p); chk("R7 ptr kept", p, 32'h0BADF00D);
    accept();
    rd(4'd11, b); chk("R7 not yet", b, 8'h40);
    @(negedge clk);
    rd_ptr(p); chk("R7 shown after accept", p, 32'hCAFE0001);
    wr(4'd11, 8'h02);

    // R8 collision: transfer vs pointer write
    @(negedge clk); done_valid = 1; done_addr = 32'hDEADBEEF;
    @(negedge clk); done_valid = 0; host_addr = 4'd1; host_wdata = 8'h55; host_wr = 1;
    @(negedge clk); host_wr = 0;
    rd(4'd1, b); chk("R8 completion wins", b, 8'hEF);
    wr(4'd11, 8'h02);

    // R7 collision: transfer vs post
    wr(4'd9, 8'h3D);
    @(negedge clk); done_valid = 1; done_addr = 32'h12345678;
    @(negedge clk); done_valid = 0; host_addr = 4'd11; host_wdata = 8'h04; host_wr = 1;
    @(negedge clk); host_wr = 0;
    chk("R7 post old ptr", cmd_addr, 32'h00ADBEEF);
    rd(4'd11, b); chk("R7 post blocks transfer", b, 8'h44);
    accept(); @(negedge clk);
    rd_ptr(p); chk("R7 transfer after post", p, 32'h12345678);
    wr(4'd11, 8'h02);

    // R9 R10 soft reset
    wr(4'd11, 8'h25);
    complete(32'h0F0F0F0F);
    wr(4'd11, 8'h08);
    rd(4'd11, b); chk("R9 busy reads", b, 8'h88);
    chk("R10 cmd_valid low", cmd_valid, 0);
    chk("R10 done_ready low", done_ready, 0);
    chk("R10 soft_rst pin", soft_rst, 1);
    rd(4'd13, b); chk("R10 fatal cleared", b, 8'h00);
    wr(4'd11, 8'h21);
    repeat (RST - 3) @(negedge clk);
    rd(4'd11, b); chk("R9 busy last cycle", b, 8'h88);
    @(negedge clk);
    rd(4'd11, b); chk("R9 busy ends", b, 8'h00);
    chk("R10 maint cleared", maint_mode, 0);
    rd_ptr(p); chk("R10 ptr kept", p, 32'h12345678);
    chk("R10 slot emptied", done_ready, 1);

    // random rounds
    for (int n = 0; n < 60; n++) begin
      a = $urandom;
      case ($urandom % 3) 0: m = 8'h3D; 1: m = 8'h0D; default: m = 8'($urandom); endcase
      load(a, m); wr(4'd11, 8'h04);
      chk("R4 random cmd_addr", cmd_addr, exp_cmd(a, m));
      chk("R2 random cmd_mod", cmd_mod, m);
      repeat ($urandom % 4) @(negedge clk);
      chk("R3 random hold", cmd_addr, exp_cmd(a, m));
      accept();
      q = $urandom;
      complete(q); @(negedge clk);
      rd_ptr(p); chk("R5 random completion", p, q);
      rd(4'd11, b); chk("R5 random flag", b, 8'h02);
      wr(4'd11, 8'h02);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule